// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory command into the stream of per-element byte addresses that a vector load or store unit sends to memory. A command carries an addressing mode, a base address, a signed stride, an element width code and the requested element count. The block accepts the command when idle. It then presents one address per cycle on a valid/ready output, together with the element size code and a flag that marks the final element.

Three modes are supported. In contiguous mode the addresses step by the element size. In strided mode they step by a signed byte stride. In indexed mode (gather or scatter) each address is the base plus an offset read from a vector register. For that read the block drives the element number on an index-select output and takes the offset back on the same cycle. The element count is capped at the largest vector length the machine holds, and a count of zero retires the command without producing any address.

Top module: `vec_addr_gen`

## Requirements
- R1: Out of reset `cmd_ready_o` is 1 and `addr_valid_o` is 0. A command is taken on a cycle where `cmd_valid_i` and `cmd_ready_o` are both high, and `cmd_ready_o` stays low while addresses of that command remain.
- R2: Mode code 0 (code 3 acts the same) is contiguous. Element i is at `base + i*2^w`, where width code w is 0, 1, 2 or 3 for 1, 2, 4 or 8 byte elements. `size_o` equals w for every element of every mode.
- R3: Mode code 1 is strided. Element i is at `base + i*stride`, where the stride is a two's-complement byte offset and the sum wraps modulo 2^ADDR_W.
- R4: Mode code 2 is indexed. While element i is presented, `idx_sel_o` equals i and the address is `base + idx_data_i`, with the sum wrapping modulo 2^ADDR_W.
- R5: A command with count n (0 < n <= MAX_VL) yields exactly n address handshakes. `last_o` is high only on element n-1.
- R6: A command with count 0 is accepted. No address is produced and `cmd_ready_o` stays high on the next cycle.
- R7: A count above MAX_VL is treated as MAX_VL.
- R8: While `addr_valid_o` is high and `addr_ready_i` is low, the next cycle keeps `addr_valid_o` high and keeps `addr_o`, `size_o`, `last_o` and `idx_sel_o` unchanged.
- R9: After the handshake of the final element, `addr_valid_o` is low and `cmd_ready_o` is high on the next cycle, and a new command can be taken there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command can be taken |
| cmd_mode_i | input | 2 | 0 contiguous, 1 strided, 2 indexed |
| cmd_width_i | input | 2 | Element size code, bytes = 2^code |
| cmd_base_i | input | ADDR_W | Base byte address |
| cmd_stride_i | input | ADDR_W | Signed byte stride (strided mode) |
| cmd_vl_i | input | VL_W | Requested element count |
| idx_sel_o | output | ELEM_W | Element number for the index register read |
| idx_data_i | input | ADDR_W | Signed index offset for the selected element |
| addr_valid_o | output | 1 | Address presented |
| addr_ready_i | input | 1 | Memory side takes the address |
| addr_o | output | ADDR_W | Element byte address |
| size_o | output | 2 | Element size code |
| last_o | output | 1 | Final element of the command |

## Verification
The hardest situations to reach are a stall that lands exactly on the final element, and a stall that meets an address that has wrapped past the top of the address space or moved downward with a negative stride. A clean hold in those cases shows that the counter and the offset accumulator freeze together. The bench drives the ready input from a pseudo-random pattern across long commands, including a full maximum-length run and a clamped over-length count, so that stalls fall on first, middle and last elements. Separate commands use a negative stride, a base near the top of memory and index values that mix signs.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    MODE_UNIT   = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_INDEX  = 2'd2,
    MODE_RSVD   = 2'd3
  } mode_e;
endpackage

// File: rtl/vag_len_ctrl.sv
module vag_len_ctrl #(
  parameter int unsigned MAX_VL = 64,
  localparam int unsigned VL_W = $clog2(MAX_VL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic            adv_i,
  output logic            busy_o,
  output logic [VL_W-1:0] cnt_o,
  output logic            last_o
);
  logic [VL_W-1:0] cnt_q, vl_q;
  logic            busy_q;

  assign last_o = busy_q && (cnt_q == vl_q - VL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      vl_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      vl_q   <= vl_i;
    end else if (adv_i) begin
      if (last_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + VL_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/vag_offset_gen.sv
module vag_offset_gen #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] step_i,
  output logic [ADDR_W-1:0] off_o
);
  logic [ADDR_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (start_i) acc_q <= '0;
    else if (adv_i)   acc_q <= acc_q + step_i;
  end

  assign off_o = acc_q;
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MAX_VL = 64,
  localparam int unsigned VL_W   = $clog2(MAX_VL + 1),
  localparam int unsigned ELEM_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_mode_i,
  input  logic [1:0]        cmd_width_i,
  input  logic [ADDR_W-1:0] cmd_base_i,
  input  logic [ADDR_W-1:0] cmd_stride_i,
  input  logic [VL_W-1:0]   cmd_vl_i,
  output logic [ELEM_W-1:0] idx_sel_o,
  input  logic [ADDR_W-1:0] idx_data_i,
  output logic              addr_valid_o,
  input  logic              addr_ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        size_o,
  output logic              last_o
);
  mode_e             mode_q;
  logic [1:0]        width_q;
  logic [ADDR_W-1:0] base_q, stride_q, step, off;
  logic [VL_W-1:0]   vl_eff, cnt;
  logic              busy, accept, start, adv;

  assign vl_eff = (cmd_vl_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : cmd_vl_i;
  assign accept = cmd_valid_i && cmd_ready_o;
  assign start  = accept && (vl_eff != '0);
  assign adv    = addr_valid_o && addr_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_UNIT;
      width_q  <= '0;
      base_q   <= '0;
      stride_q <= '0;
    end else if (start) begin
      mode_q   <= mode_e'(cmd_mode_i);
      width_q  <= cmd_width_i;
      base_q   <= cmd_base_i;
      stride_q <= cmd_stride_i;
    end
  end

  // strided uses the register stride, contiguous and reserved step by element size
  assign step = (mode_q == MODE_STRIDE) ? stride_q : (ADDR_W'(1) << width_q);

  vag_len_ctrl #(.MAX_VL(MAX_VL)) u_len (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .vl_i    (vl_eff),
    .adv_i   (adv),
    .busy_o  (busy),
    .cnt_o   (cnt),
    .last_o  (last_o)
  );

  vag_offset_gen #(.ADDR_W(ADDR_W)) u_off (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .adv_i   (adv),
    .step_i  (step),
    .off_o   (off)
  );

  assign cmd_ready_o  = !busy;
  assign addr_valid_o = busy;
  assign idx_sel_o    = cnt[ELEM_W-1:0];
  assign size_o       = width_q;
  assign addr_o       = base_q + ((mode_q == MODE_INDEX) ? idx_data_i : off);
endmodule

// File: rtl/vag_chk.sv
module vag_chk
  import vag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned VL_W   = 7,
  parameter int unsigned ELEM_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic [1:0]        cmd_mode_i,
  input logic [ADDR_W-1:0] cmd_base_i,
  input logic [VL_W-1:0]   cmd_vl_i,
  input logic [ELEM_W-1:0] idx_sel_o,
  input logic              addr_valid_o,
  input logic              addr_ready_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        size_o,
  input logic              last_o,
  input mode_e             mode_q,
  input logic [ADDR_W-1:0] stride_q
);
  logic hs, acc;
  assign hs  = addr_valid_o && addr_ready_i;
  assign acc = cmd_valid_i && cmd_ready_o;

  // R1
  cmd_taken_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && cmd_vl_i != '0 |=> addr_valid_o && !cmd_ready_o);

  // R2
  unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && !last_o && mode_q != MODE_STRIDE && mode_q != MODE_INDEX
    |=> addr_o == $past(addr_o) + (ADDR_W'(1) << $past(size_o)));

  // R3
  stride_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && !last_o && mode_q == MODE_STRIDE |=> addr_o == $past(addr_o) + stride_q);

  // R3
  first_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && cmd_vl_i != '0 && cmd_mode_i != 2'd2 |=> addr_o == $past(cmd_base_i));

  // R4
  idx_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && !last_o |=> idx_sel_o == $past(idx_sel_o) + ELEM_W'(1));

  // R6
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && cmd_vl_i == '0 |=> !addr_valid_o && cmd_ready_o);

  // R8
  hold_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && !addr_ready_i |=> addr_valid_o && $stable(addr_o) && $stable(size_o)
      && $stable(last_o) && $stable(idx_sel_o));

  // R9
  last_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && last_o |=> !addr_valid_o && cmd_ready_o);
endmodule

bind vec_addr_gen vag_chk #(.ADDR_W(ADDR_W), .VL_W(VL_W), .ELEM_W(ELEM_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_ready_o  (cmd_ready_o),
  .cmd_mode_i   (cmd_mode_i),
  .cmd_base_i   (cmd_base_i),
  .cmd_vl_i     (cmd_vl_i),
  .idx_sel_o    (idx_sel_o),
  .addr_valid_o (addr_valid_o),
  .addr_ready_i (addr_ready_i),
  .addr_o       (addr_o),
  .size_o       (size_o),
  .last_o       (last_o),
  .mode_q       (mode_q),
  .stride_q     (stride_q)
);

// File: tb/vec_addr_gen_tb.sv
module vec_addr_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int MAX_VL = 64;
  localparam int VL_W   = $clog2(MAX_VL + 1);
  localparam int ELEM_W = $clog2(MAX_VL);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0, cmd_ready;
  logic [1:0]        cmd_mode = '0, cmd_width = '0;
  logic [ADDR_W-1:0] cmd_base = '0, cmd_stride = '0;
  logic [VL_W-1:0]   cmd_vl = '0;
  logic [ELEM_W-1:0] idx_sel;
  logic [ADDR_W-1:0] idx_data;
  logic              addr_valid, addr_ready = 1'b0;
  logic [ADDR_W-1:0] addr;
  logic [1:0]        size;
  logic              last;

  logic [ADDR_W-1:0] idx_mem [MAX_VL];
  assign idx_data = idx_mem[idx_sel];

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_addr_gen #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_mode_i(cmd_mode), .cmd_width_i(cmd_width),
    .cmd_base_i(cmd_base), .cmd_stride_i(cmd_stride), .cmd_vl_i(cmd_vl),
    .idx_sel_o(idx_sel), .idx_data_i(idx_data),
    .addr_valid_o(addr_valid), .addr_ready_i(addr_ready),
    .addr_o(addr), .size_o(size), .last_o(last)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model: behavioural queue of expected addresses per command
  task automatic run_cmd(input logic [1:0] mode, input logic [1:0] width,
                         input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] stride,
                         input int vl, input bit stall, output int emitted);
    logic [ADDR_W-1:0] q[$];
    string req;
    int n;
    bit stalled;
    n = (vl > MAX_VL) ? MAX_VL : vl;
    req = (mode == 2'd1) ? "R3" : (mode == 2'd2) ? "R4" : "R2";
    for (int i = 0; i < n; i++) begin
      if (mode == 2'd1)      q.push_back(base + ADDR_W'(i) * stride);
      else if (mode == 2'd2) q.push_back(base + idx_mem[i]);
      else                   q.push_back(base + (ADDR_W'(i) << width));
    end
    emitted = 0;
    stalled = 0;
    chk("R1", "ready before command", {63'd0, cmd_ready}, 64'd1);
    cmd_valid = 1'b1; cmd_mode = mode; cmd_width = width;
    cmd_base = base; cmd_stride = stride; cmd_vl = VL_W'(vl);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (n == 0) begin
      chk("R6", "valid after empty command", {63'd0, addr_valid}, 64'd0);
      chk("R6", "ready after empty command", {63'd0, cmd_ready}, 64'd1);
      return;
    end
    while (q.size() > 0) begin
      chk("R1", "ready while busy", {63'd0, cmd_ready}, 64'd0);
      chk(stalled ? "R8" : "R5", "valid", {63'd0, addr_valid}, 64'd1);
      chk(stalled ? "R8" : req, "address", {32'd0, addr}, {32'd0, q[0]});
      chk("R2", "size", {62'd0, size}, {62'd0, width});
      chk("R5", "last flag", {63'd0, last}, {63'd0, q.size() == 1});
      chk("R4", "index select", {58'd0, idx_sel}, 64'(emitted));
      addr_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      @(negedge clk);
      stalled = !addr_ready;
      if (addr_ready) begin
        void'(q.pop_front());
        emitted++;
      end
      addr_ready = 1'b0;
    end
    chk("R9", "valid after final", {63'd0, addr_valid}, 64'd0);
    chk("R9", "ready after final", {63'd0, cmd_ready}, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cnt;
    for (int i = 0; i < MAX_VL; i++) idx_mem[i] = ADDR_W'(i * 40) - ADDR_W'(600);
    idx_mem[3] = 32'h0000_7000;
    repeat (3) @(negedge clk);
    chk("R1", "reset ready", {63'd0, cmd_ready}, 64'd1);
    chk("R1", "reset valid", {63'd0, addr_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_cmd(2'd0, 2'd3, 32'h0000_1000, 32'd0, 5, 1'b0, cnt);
    chk("R5", "count contiguous 64b", 64'(cnt), 64'd5);
    run_cmd(2'd0, 2'd0, 32'h0000_2001, 32'd0, 64, 1'b1, cnt);
    chk("R5", "count full length", 64'(cnt), 64'd64);
    run_cmd(2'd1, 2'd2, 32'h0000_4000, 32'hFFFF_FFF4, 7, 1'b1, cnt);
    chk("R3", "count negative stride", 64'(cnt), 64'd7);
    run_cmd(2'd1, 2'd1, 32'h0000_0800, 32'd256, 1, 1'b1, cnt);
    chk("R5", "count single", 64'(cnt), 64'd1);
    run_cmd(2'd2, 2'd3, 32'h0001_0000, 32'd0, 10, 1'b1, cnt);
    chk("R4", "count indexed", 64'(cnt), 64'd10);
    run_cmd(2'd0, 2'd1, 32'h0000_3000, 32'd0, 0, 1'b0, cnt);
    chk("R6", "count empty", 64'(cnt), 64'd0);
    run_cmd(2'd0, 2'd2, 32'h0000_5000, 32'd0, 100, 1'b1, cnt);
    chk("R7", "count clamped", 64'(cnt), 64'(MAX_VL));
    run_cmd(2'd1, 2'd3, 32'hFFFF_FFF0, 32'd16, 3, 1'b1, cnt);
    chk("R3", "count wrap", 64'(cnt), 64'd3);
    run_cmd(2'd3, 2'd1, 32'h0000_6000, 32'd999, 4, 1'b0, cnt);
    chk("R2", "count reserved mode", 64'(cnt), 64'd4);
    run_cmd(2'd2, 2'd0, 32'h0000_0100, 32'd0, 64, 1'b1, cnt);
    chk("R4", "count indexed full", 64'(cnt), 64'd64);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule